// File: doc/BRIEF.md
# Packed Lane Right Shifter

This block shifts a 64-bit operand right in independent packed lanes. Each operation selects four 16-bit lanes or two 32-bit lanes, and logical (zero-fill) or arithmetic (sign-fill) shifting. The shift count comes either from a 5-bit immediate or from a full 64-bit register. Every lane uses the same count, and the count is clamped to the lane width. A clamped shift therefore empties a lane completely: it becomes all zeros, or all copies of that lane's sign bit.

The block sits in an execution pipeline next to the register file. An issue strobe presents the operands together with a qualifying predicate and a destination index. One clock later the block delivers the result value and its deferred-exception tag. The tag is the OR of the source tag and, in register-count form only, the count tag. Along with these come a write enable and an illegal-operation fault flag. When the predicate is false, nothing is written and no fault is raised. Destination index 0 is the hard-wired zero register, so selecting it raises the fault instead of writing.

Top module: `lane_rshift_unit`

## Requirements
- R1: With `wide_lanes`=0, the result holds four independent 16-bit lanes at bits 15:0, 31:16, 47:32 and 63:48, each shifted right by the same count.
- R2: With `wide_lanes`=1, the result holds two independent 32-bit lanes at bits 31:0 and 63:32, each shifted right by the same count.
- R3: With `arith`=0, bits vacated at the top of each lane are filled with zeros.
- R4: With `arith`=1, bits vacated at the top of each lane are filled with that lane's bit at position lane width minus 1. A count equal to or above the lane width gives all copies of that bit.
- R5: The count is compared with the lane limit (16 or 32) over all 64 bits, unsigned. Any larger value, including 2^63 and 2^64-1, behaves as the limit.
- R6: With `cnt_from_reg`=1, the count is `cnt_reg`. With `cnt_from_reg`=0, it is `imm_cnt` zero-extended to 64 bits.
- R7: `res_tag` is `src_tag` OR'd with `cnt_tag` when `cnt_from_reg`=1, and equals `src_tag` when `cnt_from_reg`=0.
- R8: An issued operation with `pred_ok`=0 yields `wr_en`=0 and `ill_fault`=0.
- R9: An issued operation with `pred_ok`=1 and `dst_idx`=0 yields `ill_fault`=1 and `wr_en`=0. With any other index it yields `wr_en`=1 and `ill_fault`=0.
- R10: Results appear on the outputs at the first rising clock edge after the issue cycle. In any cycle that follows a cycle without `issue`, `wr_en` and `ill_fault` are 0.
- R11: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Operation presented this cycle |
| pred_ok | input | 1 | Qualifying predicate |
| wide_lanes | input | 1 | 0: 16-bit lanes, 1: 32-bit lanes |
| arith | input | 1 | 0: zero fill, 1: sign fill |
| cnt_from_reg | input | 1 | 0: immediate count, 1: register count |
| dst_idx | input | 7 | Destination register index |
| src_data | input | 64 | Operand to shift |
| src_tag | input | 1 | Deferred-exception tag of the operand |
| imm_cnt | input | 5 | Immediate shift count |
| cnt_reg | input | 64 | Register shift count |
| cnt_tag | input | 1 | Deferred-exception tag of the count register |
| res_data | output | 64 | Shifted result |
| res_tag | output | 1 | Result tag |
| wr_en | output | 1 | Write the result to the destination |
| ill_fault | output | 1 | Illegal-operation fault |

## Verification
Two things can happen on the same operation: the count clamps, and the destination check either gates or faults the write. The bench provokes this by issuing clamping counts (17, 33, 2^63, all ones) with a false predicate and with destination 0, as well as with legal writes. It judges each operation on its own. The result data and tag must match the reference model in every case. At the same time, `wr_en` and `ill_fault` must follow only the predicate and the index. A saturated shift must never disturb the write decision, and a fault must never block the data compare.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
   typedef enum logic {
      LANES_NARROW = 1'b0,
      LANES_WIDE   = 1'b1
   } lane_mode_e;

   function automatic int unsigned sh_bits(input int unsigned limit);
      return $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/lrs_count_clamp.sv
module lrs_count_clamp #(
   parameter int CNT_W = 64,
   parameter int LIMIT = 16,
   parameter int OUT_W = 6
) (
   input  logic [CNT_W-1:0] cnt_in,
   output logic [OUT_W-1:0] cnt_out
);
   if (LIMIT >= (1 << OUT_W)) begin : g_bad_out_w
      $error("OUT_W too narrow for LIMIT");
   end

   localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

   always_comb begin
      if (cnt_in > LIMIT_V) cnt_out = OUT_W'(LIMIT);
      else                  cnt_out = cnt_in[OUT_W-1:0];
   end
endmodule

// File: rtl/lrs_lane_shift.sv
module lrs_lane_shift #(
   parameter int LANE_W = 16,
   parameter int SH_W   = 6
) (
   input  logic [LANE_W-1:0] din,
   input  logic              arith,
   input  logic [SH_W-1:0]   shamt,
   output logic [LANE_W-1:0] dout
);
   logic signed [LANE_W:0] ext;
   logic signed [LANE_W:0] shifted;

   always_comb begin
      ext     = $signed({arith & din[LANE_W-1], din});
      shifted = ext >>> shamt;
      dout    = shifted[LANE_W-1:0];
   end
endmodule

// File: rtl/lrs_packed_lanes.sv
module lrs_packed_lanes #(
   parameter int DATA_W = 64,
   parameter int LANE_W = 16,
   parameter int SH_W   = 6
) (
   input  logic [DATA_W-1:0] din,
   input  logic              arith,
   input  logic [SH_W-1:0]   shamt,
   output logic [DATA_W-1:0] dout
);
   localparam int N_LANES = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0) begin : g_bad_split
      $error("DATA_W must be a multiple of LANE_W");
   end

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      lrs_lane_shift #(.LANE_W(LANE_W), .SH_W(SH_W)) u_lane (
         .din   (din[g*LANE_W +: LANE_W]),
         .arith (arith),
         .shamt (shamt),
         .dout  (dout[g*LANE_W +: LANE_W])
      );
   end
endmodule

// File: rtl/lane_rshift_unit.sv
module lane_rshift_unit #(
   parameter int DATA_W   = 64,
   parameter int NARROW_W = 16,
   parameter int WIDE_W   = 32,
   parameter int IMM_W    = 5,
   parameter int IDX_W    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic              pred_ok,
   input  logic              wide_lanes,
   input  logic              arith,
   input  logic              cnt_from_reg,
   input  logic [IDX_W-1:0]  dst_idx,
   input  logic [DATA_W-1:0] src_data,
   input  logic              src_tag,
   input  logic [IMM_W-1:0]  imm_cnt,
   input  logic [DATA_W-1:0] cnt_reg,
   input  logic              cnt_tag,
   output logic [DATA_W-1:0] res_data,
   output logic              res_tag,
   output logic              wr_en,
   output logic              ill_fault
);
   import lrs_pkg::*;

   localparam int SH_W = sh_bits(WIDE_W);

   if (WIDE_W <= NARROW_W || DATA_W % WIDE_W != 0 || DATA_W % NARROW_W != 0)
   begin : g_bad_widths
      $error("lane widths must divide DATA_W and WIDE_W must exceed NARROW_W");
   end
   if (IMM_W >= DATA_W) begin : g_bad_imm
      $error("IMM_W must be narrower than DATA_W");
   end

   logic [DATA_W-1:0] cnt_full;
   logic [SH_W-1:0]   sh_narrow, sh_wide;
   logic [DATA_W-1:0] out_narrow, out_wide, nxt_data;
   logic              nxt_tag, idx_legal;
   lane_mode_e        mode;

   assign mode      = lane_mode_e'(wide_lanes);
   assign cnt_full  = cnt_from_reg ? cnt_reg : {{(DATA_W-IMM_W){1'b0}}, imm_cnt};
   assign idx_legal = (dst_idx != '0);

   lrs_count_clamp #(.CNT_W(DATA_W), .LIMIT(NARROW_W), .OUT_W(SH_W)) u_clamp_n (
      .cnt_in (cnt_full), .cnt_out (sh_narrow));
   lrs_count_clamp #(.CNT_W(DATA_W), .LIMIT(WIDE_W), .OUT_W(SH_W)) u_clamp_w (
      .cnt_in (cnt_full), .cnt_out (sh_wide));

   lrs_packed_lanes #(.DATA_W(DATA_W), .LANE_W(NARROW_W), .SH_W(SH_W)) u_lanes_n (
      .din (src_data), .arith (arith), .shamt (sh_narrow), .dout (out_narrow));
   lrs_packed_lanes #(.DATA_W(DATA_W), .LANE_W(WIDE_W), .SH_W(SH_W)) u_lanes_w (
      .din (src_data), .arith (arith), .shamt (sh_wide), .dout (out_wide));

   always_comb begin
      nxt_data = (mode == LANES_WIDE) ? out_wide : out_narrow;
      nxt_tag  = src_tag | (cnt_from_reg & cnt_tag);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_data  <= '0;
         res_tag   <= 1'b0;
         wr_en     <= 1'b0;
         ill_fault <= 1'b0;
      end else begin
         wr_en     <= issue & pred_ok & idx_legal;
         ill_fault <= issue & pred_ok & ~idx_legal;
         if (issue) begin
            res_data <= nxt_data;
            res_tag  <= nxt_tag;
         end
      end
   end

   // write and fault never together
   assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && ill_fault));

   assert_pred_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !pred_ok) |=> (!wr_en && !ill_fault));

   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> (!wr_en && !ill_fault));

   assert_imm_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !cnt_from_reg) |=> (res_tag == $past(src_tag)));

   assert_zero_cnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !cnt_from_reg && imm_cnt == '0) |=> (res_data == $past(src_data)));

   assert_clamp_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && cnt_from_reg && !arith && cnt_reg >= DATA_W'(WIDE_W)) |=> (res_data == '0));

   assert_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && pred_ok && dst_idx == '0) |=> ill_fault);
endmodule

// File: tb/lane_rshift_unit_tb.sv
module lane_rshift_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue = 1'b0, pred_ok = 1'b0, wide_lanes = 1'b0, arith = 1'b0;
   logic        cnt_from_reg = 1'b0, src_tag = 1'b0, cnt_tag = 1'b0;
   logic [6:0]  dst_idx = '0;
   logic [63:0] src_data = '0, cnt_reg = '0;
   logic [4:0]  imm_cnt = '0;
   logic [63:0] res_data;
   logic        res_tag, wr_en, ill_fault;

   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   lane_rshift_unit u_dut (
      .clk, .rst_n, .issue, .pred_ok, .wide_lanes, .arith, .cnt_from_reg,
      .dst_idx, .src_data, .src_tag, .imm_cnt, .cnt_reg, .cnt_tag,
      .res_data, .res_tag, .wr_en, .ill_fault);

   function automatic logic [63:0] ref_shift(logic [63:0] d, bit wide, bit ar, logic [63:0] c);
      int lw, sh;
      logic [63:0] r;
      lw = wide ? 32 : 16;
      sh = (c > 64'(lw)) ? lw : int'(c[5:0]);
      r = '0;
      for (int l = 0; l < 64 / lw; l++) begin
         logic [31:0] v;
         logic sgn;
         v = wide ? d[l*32 +: 32] : {16'b0, d[l*16 +: 16]};
         sgn = ar & v[lw-1];
         for (int b = 0; b < lw; b++)
            r[l*lw + b] = (b + sh < lw) ? v[b + sh] : sgn;
      end
      return r;
   endfunction

   task automatic check(string req, logic [63:0] got, logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // issue one operation and check the outputs one edge later
   task automatic run_op(string req, bit wide, bit ar, bit fromreg, logic [63:0] d,
                         logic [4:0] imm, logic [63:0] creg, bit st, bit ct,
                         bit pr, logic [6:0] idx);
      logic [63:0] c;
      issue = 1'b1; pred_ok = pr; wide_lanes = wide; arith = ar;
      cnt_from_reg = fromreg; src_data = d; imm_cnt = imm; cnt_reg = creg;
      src_tag = st; cnt_tag = ct; dst_idx = idx;
      @(negedge clk);
      c = fromreg ? creg : {59'b0, imm};
      check(req, res_data, ref_shift(d, wide, ar, c));
      check({req, " R7 tag"}, 64'(res_tag), 64'(st | (fromreg & ct)));
      check({req, " R8/R9 wr"}, 64'(wr_en), 64'(pr && idx != 0));
      check({req, " R8/R9 fault"}, 64'(ill_fault), 64'(pr && idx == 0));
      issue = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      logic [63:0] corner [9];
      void'($urandom(32'd1234));
      corner[0] = 64'd0;  corner[1] = 64'd15; corner[2] = 64'd16;
      corner[3] = 64'd17; corner[4] = 64'd31; corner[5] = 64'd32;
      corner[6] = 64'd33; corner[7] = {1'b1, 63'b0}; corner[8] = '1;
      @(negedge clk);
      // R11: reset state
      check("R11 reset data", res_data, 64'd0);
      check("R11 reset flags", {61'd0, res_tag, wr_en, ill_fault}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 R3: narrow lanes, logical
      run_op("R1 R3 narrow logical", 0, 0, 0, 64'h8001_7FFF_F0F0_0F0F, 5'd4, 0, 0, 0, 1, 7'd5);
      // R2 R4: wide lanes, arithmetic
      run_op("R2 R4 wide arith", 1, 1, 0, 64'h8000_0001_7000_0000, 5'd31, 0, 0, 0, 1, 7'd9);
      // R4: clamped arithmetic gives sign copies per lane
      run_op("R4 narrow sign fill", 0, 1, 1, 64'h8000_1234_FFFF_7FFF, 0, 64'd40, 0, 0, 1, 7'd3);
      // R5: huge counts clamp
      run_op("R5 clamp 2^63", 1, 1, 1, 64'h9000_0000_0FFF_FFFF, 0, {1'b1, 63'b0}, 0, 1, 1, 7'd2);
      // R6: register count ignores immediate
      run_op("R6 reg count", 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 5'd1, 64'd8, 1, 0, 1, 7'd4);
      // R7: immediate form ignores count tag
      run_op("R7 imm tag", 1, 0, 0, 64'h1234_5678_9ABC_DEF0, 5'd3, 0, 0, 1, 1, 7'd4);
      // R8 with clamping count at the same time
      run_op("R8 pred false", 0, 1, 1, 64'hA5A5_5A5A_8000_0001, 0, 64'd17, 0, 0, 0, 7'd6);
      // R9 with clamping count at the same time
      run_op("R9 idx zero", 1, 0, 1, 64'hDEAD_BEEF_CAFE_F00D, 0, '1, 1, 1, 1, 7'd0);
      // R10: idle cycle clears flags
      @(negedge clk);
      check("R10 idle", {62'd0, wr_en, ill_fault}, 64'd0);
      // corner counts in every mode
      for (int m = 0; m < 4; m++)
         for (int k = 0; k < 9; k++)
            run_op("R5 corner count", m[1], m[0], 1, {$urandom, $urandom}, 0, corner[k],
                   1'($urandom), 1'($urandom), 1, 7'($urandom_range(1, 127)));
      // random operations
      for (int i = 0; i < 400; i++)
         run_op("R1 R2 random", 1'($urandom), 1'($urandom), 1'($urandom),
                {$urandom, $urandom}, 5'($urandom),
                ($urandom_range(0, 3) == 0) ? {$urandom, $urandom} : 64'($urandom_range(0, 40)),
                1'($urandom), 1'($urandom), 1'($urandom_range(0, 7) != 0),
                7'($urandom_range(0, 7) == 0 ? 0 : $urandom_range(1, 127)));
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule